// File: doc/BRIEF.md
# Network Controller Command and Interrupt Core

This block is the host-facing control core of a packet network controller. Software programs it through a byte-wide register port, with one write strobe and a combinational read path. A command byte starts and stops the controller and raises a transmit request. It also carries a three-bit remote-transfer opcode and a two-bit field that selects which register page the other offsets reach. An interrupt status byte collects event pulses from the receive, transmit, remote-transfer and statistics logic. A mask byte decides which of those events drive the single interrupt line.

A stop command never cuts a frame short. When either the receive or the transmit side reports a frame in flight, the core holds in a draining state. It goes offline only when both sides are idle. Entering the offline state raises a reset-status flag, and that flag has set and clear rules of its own. The core also keeps the remote-transfer address counter. The counter steps once for each byte the transfer engine moves. An abort freezes the counter where it stands.

Top module: `nic_cmd_irq_ctrl`

## Requirements
- R1: After reset the command byte (offset 0) reads 0x21, which is offline with the idle opcode 100 and page 0. The status byte reads 0x80, the mask reads 0x00, and irq is low.
- R2: A command write with bit 0 clear and bit 1 set brings the controller online (`running` high, command bit 1 reads 1, bit 0 reads 0) and clears status bit 7. A write with both bit 0 and bit 1 set does not bring it online.
- R3: A command write with bit 0 set takes the controller offline at the next edge if `rx_busy` and `tx_busy` are both low. Otherwise command bit 0 reads 1 while status bit 7 stays clear, until both busy inputs are low. Status bit 7 is set in the cycle the offline state is entered.
- R4: Writing command bit 2 as 1 while online sets `tx_req`. A pulse on `ev_tx_ok` or `ev_tx_err` clears it. Writing bit 2 as 0 leaves it set, and a write of 1 while offline is ignored.
- R5: Command bits 5:3 hold the remote opcode, drive `rdma_op` and set `rdma_active`: 001 read, 010 write, 011 send. A code with bit 5 set stores 100, clears `rdma_active` and gives a one-cycle `rdma_abort` pulse. The code 000 leaves the field unchanged. `ev_rdma_done` stores 100.
- R6: In page 0, writes to offsets 8 and 9 load the low and high bytes of `rdma_addr`, and reads of those offsets return them. While `rdma_active` is high, each `rdma_step` pulse adds one, wrapping at the top. While it is low, steps have no effect, and an abort does not restore an earlier value.
- R7: Command bits 7:6 select page 00, 01 or 10. Code 11 is rejected and the previous page is kept. The status byte (offset 7) is reached only in page 0. The mask is written at offset 15 in page 0 and read at offset 15 in page 2. Any other offset and page reads 0.
- R8: Status bits 0 to 6 are set by `ev_rx_ok`, `ev_tx_ok`, `ev_rx_err`, `ev_tx_err`, `ev_ring_ovw`, `ev_cnt_msb` and `ev_rdma_done` respectively. Writing 1 to a bit clears it. An event in the same cycle as the clear wins.
- R9: Status bit 7 is also set by `ev_ring_ovw` and cleared by `ev_ring_free`. Software writes do not change it.
- R10: `irq` is the OR over bits 0 to 6 of status AND mask. Mask bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr in the current page |
| rx_busy | input | 1 | A frame is being received |
| tx_busy | input | 1 | A frame is being transmitted |
| ev_rx_ok | input | 1 | Frame received without error |
| ev_tx_ok | input | 1 | Frame sent without error |
| ev_rx_err | input | 1 | Receive error |
| ev_tx_err | input | 1 | Transmit error or abort |
| ev_ring_ovw | input | 1 | Receive ring overwrite |
| ev_cnt_msb | input | 1 | Statistics counter MSB set |
| ev_rdma_done | input | 1 | Remote transfer finished |
| ev_ring_free | input | 1 | A packet was removed from the ring |
| rdma_step | input | 1 | Remote transfer moved one byte |
| running | output | 1 | Controller online |
| tx_req | output | 1 | Transmit request pending |
| rdma_op | output | 2 | Remote opcode low bits |
| rdma_active | output | 1 | Remote opcode is a transfer |
| rdma_abort | output | 1 | One-cycle abort pulse |
| rdma_addr | output | RA_W | Remote transfer address counter |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the core with its default values, a 4-bit register offset and a 16-bit remote address. With a 16-bit counter the wrap from 0xFFFF to 0x0000 takes only a few step pulses once both address bytes are loaded near the top. A 4-bit offset reaches offset 15, where the mask is written in one page and read in another, so the page-dependent decode is exercised. The same settings let a single run cover the draining hold, the rejected page code and the ignored opcode.

// File: rtl/nic_ctrl_pkg.sv
package nic_ctrl_pkg;

  typedef enum logic [1:0] {
    RS_RUN   = 2'd0,
    RS_DRAIN = 2'd1,
    RS_OFF   = 2'd2
  } run_state_e;

  // command byte fields
  localparam int CB_STOP  = 0;
  localparam int CB_START = 1;
  localparam int CB_TXREQ = 2;
  localparam int CB_OP_LO = 3;
  localparam int CB_OP_HI = 5;
  localparam int CB_PG_LO = 6;
  localparam int CB_PG_HI = 7;

  localparam logic [2:0] OP_IDLE    = 3'b100;
  localparam logic [2:0] OP_ILLEGAL = 3'b000;
  localparam logic [1:0] PG_RSVD    = 2'b11;

  // status byte
  localparam int NUM_EV = 7;
  localparam int SB_RST = 7;

  // register offsets
  localparam int OFS_CMD    = 0;
  localparam int OFS_STAT   = 7;
  localparam int OFS_ADR_LO = 8;
  localparam int OFS_ADR_HI = 9;
  localparam int OFS_MASK   = 15;

endpackage

// File: rtl/nic_run_seq.sv
module nic_run_seq
  import nic_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic       stop_bit,
  input  logic       start_bit,
  input  logic       rx_busy,
  input  logic       tx_busy,
  output run_state_e state_q,
  output logic       running,
  output logic       enter_off,
  output logic       start_cmd
);

  run_state_e state_d;
  logic       stop_req;
  logic       any_busy;

  assign stop_req  = cmd_wr & stop_bit;
  assign start_cmd = cmd_wr & ~stop_bit & start_bit;
  assign any_busy  = rx_busy | tx_busy;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RS_RUN: begin
        if (stop_req) state_d = any_busy ? RS_DRAIN : RS_OFF;
      end
      RS_DRAIN: begin
        if (start_cmd)      state_d = RS_RUN;
        else if (!any_busy) state_d = RS_OFF;
      end
      RS_OFF: begin
        if (start_cmd) state_d = RS_RUN;
      end
      default: state_d = RS_OFF;
    endcase
  end

  assign enter_off = (state_q != RS_OFF) && (state_d == RS_OFF);
  assign running   = (state_q == RS_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RS_OFF;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/nic_cmd_reg.sv
module nic_cmd_reg
  import nic_ctrl_pkg::*;
#(
  parameter int RA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_wr,
  input  logic [7:0]      wdata,
  input  logic            running,
  input  logic            tx_done,
  input  logic            rdma_done,
  input  logic            alo_wr,
  input  logic            ahi_wr,
  input  logic            rdma_step,
  output logic            txreq_q,
  output logic [2:0]      op_q,
  output logic [1:0]      page_q,
  output logic            abort_q,
  output logic [RA_W-1:0] addr_q
);

  localparam int HI_W = RA_W - 8;

  logic            txreq_en, txreq_d;
  logic            op_en;
  logic [2:0]      op_d, op_wr;
  logic            page_en;
  logic [1:0]      page_wr;
  logic            abort_d;
  logic            addr_en;
  logic [RA_W-1:0] addr_d;

  assign op_wr   = wdata[CB_OP_HI:CB_OP_LO];
  assign page_wr = wdata[CB_PG_HI:CB_PG_LO];

  // transmit request: a write while online wins over completion
  always_comb begin
    txreq_en = 1'b0;
    txreq_d  = txreq_q;
    if (cmd_wr && wdata[CB_TXREQ] && running) begin
      txreq_en = 1'b1;
      txreq_d  = 1'b1;
    end else if (tx_done) begin
      txreq_en = 1'b1;
      txreq_d  = 1'b0;
    end
  end

  // remote opcode: abort code, legal codes, then completion
  always_comb begin
    op_en = 1'b0;
    op_d  = op_q;
    if (cmd_wr && op_wr[2]) begin
      op_en = 1'b1;
      op_d  = OP_IDLE;
    end else if (cmd_wr && (op_wr != OP_ILLEGAL)) begin
      op_en = 1'b1;
      op_d  = op_wr;
    end else if (rdma_done) begin
      op_en = 1'b1;
      op_d  = OP_IDLE;
    end
  end

  assign abort_d = cmd_wr & op_wr[2];
  assign page_en = cmd_wr & (page_wr != PG_RSVD);

  // address counter: software load first, then stepping while active
  always_comb begin
    addr_en = 1'b0;
    addr_d  = addr_q;
    if (alo_wr) begin
      addr_en = 1'b1;
      addr_d  = {addr_q[RA_W-1:8], wdata};
    end else if (ahi_wr) begin
      addr_en = 1'b1;
      addr_d  = {wdata[HI_W-1:0], addr_q[7:0]};
    end else if (rdma_step && !op_q[2]) begin
      addr_en = 1'b1;
      addr_d  = addr_q + RA_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        txreq_q <= 1'b0;
    else if (txreq_en) txreq_q <= txreq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     op_q <= OP_IDLE;
    else if (op_en) op_q <= op_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       page_q <= 2'b00;
    else if (page_en) page_q <= page_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) abort_q <= 1'b0;
    else        abort_q <= abort_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

endmodule

// File: rtl/nic_irq_unit.sv
module nic_irq_unit
  import nic_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev,
  input  logic              stat_wr,
  input  logic              mask_wr,
  input  logic [7:0]        wdata,
  input  logic              enter_off,
  input  logic              start_cmd,
  input  logic              ring_ovw,
  input  logic              ring_free,
  output logic [7:0]        stat_q,
  output logic [NUM_EV-1:0] mask_q,
  output logic              irq
);

  logic [NUM_EV-1:0] ev_bits_q;
  logic              rst_bit_q;
  logic              rst_en, rst_d;

  // per-event status flops: an event sets, a written 1 clears, event wins
  for (genvar i = 0; i < NUM_EV; i++) begin : g_stat
    logic bit_q;
    logic bit_en;
    assign bit_en = ev[i] | (stat_wr & wdata[i]);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_en) bit_q <= ev[i];
    end
    assign ev_bits_q[i] = bit_q;
  end

  // offline / overwrite flag: set sources win over clear sources
  always_comb begin
    rst_en = 1'b0;
    rst_d  = rst_bit_q;
    if (enter_off || ring_ovw) begin
      rst_en = 1'b1;
      rst_d  = 1'b1;
    end else if (start_cmd || ring_free) begin
      rst_en = 1'b1;
      rst_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rst_bit_q <= 1'b1;
    else if (rst_en) rst_bit_q <= rst_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wdata[NUM_EV-1:0];
  end

  assign stat_q = {rst_bit_q, ev_bits_q};
  assign irq    = |(ev_bits_q & mask_q);

endmodule

// File: rtl/nic_cmd_irq_ctrl.sv
module nic_cmd_irq_ctrl
  import nic_ctrl_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int RA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              rx_busy,
  input  logic              tx_busy,
  input  logic              ev_rx_ok,
  input  logic              ev_tx_ok,
  input  logic              ev_rx_err,
  input  logic              ev_tx_err,
  input  logic              ev_ring_ovw,
  input  logic              ev_cnt_msb,
  input  logic              ev_rdma_done,
  input  logic              ev_ring_free,
  input  logic              rdma_step,
  output logic              running,
  output logic              tx_req,
  output logic [1:0]        rdma_op,
  output logic              rdma_active,
  output logic              rdma_abort,
  output logic [RA_W-1:0]   rdma_addr,
  output logic              irq
);

  localparam logic [REG_AW-1:0] A_CMD  = REG_AW'(OFS_CMD);
  localparam logic [REG_AW-1:0] A_STAT = REG_AW'(OFS_STAT);
  localparam logic [REG_AW-1:0] A_ALO  = REG_AW'(OFS_ADR_LO);
  localparam logic [REG_AW-1:0] A_AHI  = REG_AW'(OFS_ADR_HI);
  localparam logic [REG_AW-1:0] A_MASK = REG_AW'(OFS_MASK);

  run_state_e        state_q;
  logic              enter_off, start_cmd;
  logic              cmd_wr, stat_wr, mask_wr, alo_wr, ahi_wr;
  logic              pg0, pg2;
  logic              txreq_q, abort_q;
  logic [2:0]        op_q;
  logic [1:0]        page_q;
  logic [RA_W-1:0]   addr_q;
  logic [7:0]        stat_q;
  logic [NUM_EV-1:0] mask_q;
  logic [NUM_EV-1:0] ev_vec;
  logic [7:0]        cmd_rb;

  // register write decode
  assign pg0     = (page_q == 2'b00);
  assign pg2     = (page_q == 2'b10);
  assign cmd_wr  = reg_wr && (reg_addr == A_CMD);
  assign stat_wr = reg_wr && pg0 && (reg_addr == A_STAT);
  assign mask_wr = reg_wr && pg0 && (reg_addr == A_MASK);
  assign alo_wr  = reg_wr && pg0 && (reg_addr == A_ALO);
  assign ahi_wr  = reg_wr && pg0 && (reg_addr == A_AHI);

  assign ev_vec = {ev_rdma_done, ev_cnt_msb, ev_ring_ovw, ev_tx_err,
                   ev_rx_err, ev_tx_ok, ev_rx_ok};

  nic_run_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .stop_bit  (reg_wdata[CB_STOP]),
    .start_bit (reg_wdata[CB_START]),
    .rx_busy   (rx_busy),
    .tx_busy   (tx_busy),
    .state_q   (state_q),
    .running   (running),
    .enter_off (enter_off),
    .start_cmd (start_cmd)
  );

  nic_cmd_reg #(.RA_W(RA_W)) u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .wdata     (reg_wdata),
    .running   (running),
    .tx_done   (ev_tx_ok | ev_tx_err),
    .rdma_done (ev_rdma_done),
    .alo_wr    (alo_wr),
    .ahi_wr    (ahi_wr),
    .rdma_step (rdma_step),
    .txreq_q   (txreq_q),
    .op_q      (op_q),
    .page_q    (page_q),
    .abort_q   (abort_q),
    .addr_q    (addr_q)
  );

  nic_irq_unit u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ev        (ev_vec),
    .stat_wr   (stat_wr),
    .mask_wr   (mask_wr),
    .wdata     (reg_wdata),
    .enter_off (enter_off),
    .start_cmd (start_cmd),
    .ring_ovw  (ev_ring_ovw),
    .ring_free (ev_ring_free),
    .stat_q    (stat_q),
    .mask_q    (mask_q),
    .irq       (irq)
  );

  assign cmd_rb = {page_q, op_q, txreq_q, running, (state_q != RS_RUN)};

  // read mux
  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == A_CMD)                reg_rdata = cmd_rb;
    else if (pg0 && reg_addr == A_STAT)   reg_rdata = stat_q;
    else if (pg0 && reg_addr == A_ALO)    reg_rdata = addr_q[7:0];
    else if (pg0 && reg_addr == A_AHI)    reg_rdata = 8'(addr_q[RA_W-1:8]);
    else if (pg2 && reg_addr == A_MASK)   reg_rdata = {1'b0, mask_q};
  end

  assign tx_req      = txreq_q;
  assign rdma_op     = op_q[1:0];
  assign rdma_active = ~op_q[2];
  assign rdma_abort  = abort_q;
  assign rdma_addr   = addr_q;

endmodule

// File: rtl/nic_ctrl_chk.sv
module nic_ctrl_chk
  import nic_ctrl_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int RA_W   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              rx_busy,
  input logic              tx_busy,
  input logic              ev_tx_ok,
  input logic              ev_tx_err,
  input logic              ev_ring_ovw,
  input logic              running,
  input logic              tx_req,
  input logic              rdma_active,
  input logic              rdma_abort,
  input logic [RA_W-1:0]   rdma_addr,
  input logic              irq,
  input logic [6:0]        mask_q,
  input logic [7:0]        stat_q,
  input run_state_e        state_q
);

  logic cmd_w, addr_w;
  assign cmd_w  = reg_wr && (reg_addr == REG_AW'(OFS_CMD));
  assign addr_w = reg_wr && ((reg_addr == REG_AW'(OFS_ADR_LO)) ||
                             (reg_addr == REG_AW'(OFS_ADR_HI)));

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RS_DRAIN && (rx_busy || tx_busy) &&
     !(cmd_w && !reg_wdata[0] && reg_wdata[1])) |=> (state_q == RS_DRAIN)); // R3

  AST_TXREQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req && (ev_tx_ok || ev_tx_err) && !(cmd_w && reg_wdata[2])) |=> !tx_req); // R4

  AST_TXREQ_ONLINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req) |-> $past(running)); // R4

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    rdma_abort |-> !rdma_active); // R5

  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rdma_active && !addr_w) |=> $stable(rdma_addr)); // R6

  AST_RST_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[SB_RST]) |-> (!running || $past(ev_ring_ovw))); // R9

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != 7'd0)); // R10

endmodule

bind nic_cmd_irq_ctrl nic_ctrl_chk #(.REG_AW(REG_AW), .RA_W(RA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr      (reg_wr),
  .reg_addr    (reg_addr),
  .reg_wdata   (reg_wdata),
  .rx_busy     (rx_busy),
  .tx_busy     (tx_busy),
  .ev_tx_ok    (ev_tx_ok),
  .ev_tx_err   (ev_tx_err),
  .ev_ring_ovw (ev_ring_ovw),
  .running     (running),
  .tx_req      (tx_req),
  .rdma_active (rdma_active),
  .rdma_abort  (rdma_abort),
  .rdma_addr   (rdma_addr),
  .irq         (irq),
  .mask_q      (mask_q),
  .stat_q      (stat_q),
  .state_q     (state_q)
);

// File: tb/sim_nic_cmd_irq_ctrl.sv
`timescale 1ns/1ps
module sim_nic_cmd_irq_ctrl;

  localparam int REG_AW = 4;
  localparam int RA_W   = 16;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr;
  logic [REG_AW-1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic rx_busy, tx_busy;
  logic ev_rx_ok, ev_tx_ok, ev_rx_err, ev_tx_err, ev_ring_ovw, ev_cnt_msb;
  logic ev_rdma_done, ev_ring_free, rdma_step;
  logic running, tx_req, rdma_active, rdma_abort, irq;
  logic [1:0] rdma_op;
  logic [RA_W-1:0] rdma_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  nic_cmd_irq_ctrl #(.REG_AW(REG_AW), .RA_W(RA_W)) u0 (.*);

  typedef struct packed {
    logic       rd;
    logic [3:0] a;
    logic [7:0] d;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 4'h0, 8'h21, 8'd1},  // R1 command byte after reset
    '{1'b1, 4'h7, 8'h80, 8'd1},  // R1 status after reset
    '{1'b0, 4'h0, 8'h02, 8'd2},  // start, opcode 000 ignored
    '{1'b1, 4'h0, 8'h22, 8'd2},  // R2 online
    '{1'b1, 4'h7, 8'h00, 8'd2},  // R2 status bit 7 cleared
    '{1'b0, 4'hF, 8'hFF, 8'd10}, // mask write in page 0
    '{1'b1, 4'hF, 8'h00, 8'd7},  // R7 mask not readable in page 0
    '{1'b0, 4'h0, 8'h82, 8'd7},  // page 2
    '{1'b1, 4'hF, 8'h7F, 8'd10}, // R10 mask bit 7 reads 0
    '{1'b0, 4'h0, 8'hC2, 8'd7},  // reserved page code
    '{1'b1, 4'h0, 8'hA2, 8'd7},  // R7 page kept at 10
    '{1'b1, 4'h7, 8'h00, 8'd7},  // R7 status hidden outside page 0
    '{1'b0, 4'h0, 8'h42, 8'd7},  // page 1
    '{1'b1, 4'hF, 8'h00, 8'd7},  // R7 no mask in page 1
    '{1'b0, 4'h0, 8'h0A, 8'd5},  // page 0, remote read
    '{1'b1, 4'h0, 8'h0A, 8'd5},  // R5 opcode 001
    '{1'b0, 4'h8, 8'h34, 8'd6},
    '{1'b0, 4'h9, 8'h12, 8'd6},
    '{1'b1, 4'h8, 8'h34, 8'd6},  // R6 low byte
    '{1'b1, 4'h9, 8'h12, 8'd6},  // R6 high byte
    '{1'b0, 4'h0, 8'h06, 8'd4},  // transmit request, opcode 000 kept 001
    '{1'b1, 4'h0, 8'h0E, 8'd4},  // R4 tx request set
    '{1'b0, 4'h0, 8'h22, 8'd5}   // abort
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [7:0] exp);
    reg_addr = a;
    #0.5;
    chk(tag, {24'd0, reg_rdata}, {24'd0, exp});
  endtask

  // bit order: rx_ok tx_ok rx_err tx_err ovw cnt rdma_done ring_free
  task automatic pulse(input logic [7:0] m);
    @(negedge clk);
    {ev_ring_free, ev_rdma_done, ev_cnt_msb, ev_ring_ovw,
     ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok} = m;
    @(negedge clk);
    {ev_ring_free, ev_rdma_done, ev_cnt_msb, ev_ring_ovw,
     ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok} = 8'h00;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rdma_step = 1'b1;
      @(negedge clk); rdma_step = 1'b0;
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rx_busy = 0; tx_busy = 0; rdma_step = 0;
    {ev_ring_free, ev_rdma_done, ev_cnt_msb, ev_ring_ovw,
     ev_tx_err, ev_rx_err, ev_tx_ok, ev_rx_ok} = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    chk("R1 running", {31'd0, running}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (TBL[i].rd) begin
        reg_addr = TBL[i].a;
        #0.5;
        checks++;
        if (reg_rdata !== TBL[i].d) begin
          errors++;
          $display("FAIL R%0d row %0d: actual 0x%0h expected 0x%0h",
                   TBL[i].req, i, reg_rdata, TBL[i].d);
        end
      end else begin
        wr(TBL[i].a, TBL[i].d);
      end
    end

    // R5 abort result and pulse
    chk("R5 abort pulse", {31'd0, rdma_abort}, 32'd1);
    rd("R5 abort clears opcode", 4'h0, 8'h26);
    @(negedge clk);
    chk("R5 abort one cycle", {31'd0, rdma_abort}, 32'd0);

    // R4 completion clears request; R8/R10 status and irq
    pulse(8'h02);
    chk("R4 tx_req cleared", {31'd0, tx_req}, 32'd0);
    rd("R8 tx ok bit", 4'h7, 8'h02);
    chk("R10 irq on masked event", {31'd0, irq}, 32'd1);
    wr(4'h7, 8'h02);
    rd("R8 write-1 clear", 4'h7, 8'h00);
    chk("R10 irq drops", {31'd0, irq}, 32'd0);

    // R8 several events, R9 overwrite sets bit 7
    pulse(8'h2D);
    rd("R8 event bits", 4'h7, 8'h2D);
    pulse(8'h10);
    rd("R9 overwrite sets bit 7", 4'h7, 8'hBD);
    wr(4'h7, 8'hFF);
    rd("R9 bit 7 not writable", 4'h7, 8'h80);
    pulse(8'h80);
    rd("R9 ring free clears", 4'h7, 8'h00);

    // R8 event wins over same-cycle clear
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h7; reg_wdata = 8'h01; ev_rx_ok = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; ev_rx_ok = 1'b0;
    rd("R8 event beats clear", 4'h7, 8'h01);
    wr(4'h7, 8'h01);

    // R10 mask selects
    wr(4'hF, 8'h01);
    pulse(8'h02);
    chk("R10 unmasked bit no irq", {31'd0, irq}, 32'd0);
    pulse(8'h01);
    chk("R10 masked bit irq", {31'd0, irq}, 32'd1);
    wr(4'h7, 8'h03);
    chk("R10 irq cleared", {31'd0, irq}, 32'd0);

    // R5/R6 remote write, stepping, wrap, abort freeze
    wr(4'h0, 8'h12);
    chk("R5 active write", {29'd0, rdma_active, rdma_op}, {29'd0, 3'b110});
    wr(4'h8, 8'hFE);
    wr(4'h9, 8'hFF);
    step(3);
    chk("R6 wrap", {16'd0, rdma_addr}, 32'h0001);
    wr(4'h0, 8'h22);
    step(2);
    chk("R6 frozen after abort", {16'd0, rdma_addr}, 32'h0001);

    // R5 completion
    wr(4'h0, 8'h1A);
    chk("R5 send opcode", {30'd0, rdma_op}, 32'd3);
    pulse(8'h40);
    chk("R5 done idles", {31'd0, rdma_active}, 32'd0);
    rd("R8 rdma done bit", 4'h7, 8'h40);
    wr(4'h7, 8'h40);

    // R3 drain hold, R4 ignored while offline
    tx_busy = 1'b1;
    wr(4'h0, 8'h01);
    rd("R3 draining reads stop", 4'h0, 8'h21);
    repeat (3) @(negedge clk);
    rd("R3 no reset status yet", 4'h7, 8'h00);
    wr(4'h0, 8'h05);
    chk("R4 ignored offline", {31'd0, tx_req}, 32'd0);
    tx_busy = 1'b0;
    @(negedge clk);
    rd("R3 offline after drain", 4'h7, 8'h80);

    // R2 both bits set does not start
    wr(4'h0, 8'h03);
    chk("R2 stop wins", {31'd0, running}, 32'd0);
    wr(4'h0, 8'h02);
    chk("R2 started", {31'd0, running}, 32'd1);
    rd("R2 status cleared", 4'h7, 8'h00);

    // R3 immediate stop
    wr(4'h0, 8'h01);
    rd("R3 immediate offline", 4'h7, 8'h80);
    rd("R3 command readback", 4'h0, 8'h21);

    finish_run();
  end

endmodule